// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is an operand stack with a small integer datapath attached. A caller hands it one command at a time over a valid/ready handshake. A command either places a data word on the stack, removes the top word and returns it, or applies a binary operation. Binary operations carry no operand addresses. They take their two operands from the two topmost entries and leave a single result in their place.

The operand order is fixed: the entry just below the top is the left operand and the top is the right operand. Subtraction therefore yields next-minus-top and division yields next-divided-by-top. Addition, subtraction and multiplication finish in one cycle. Division uses an iterative restoring divider and holds `cmd_ready` low until it has written its quotient.

The current top entry and the depth are always visible. Three error flags report overflow, underflow and division by zero for the most recent command.

Top module: `stack_calc`

## Requirements
- R1: After a synchronous active-low reset, depth is 0, tos is 0, all error flags and pop_valid are 0, and cmd_ready is 1.
- R2: A command is accepted on a rising edge where cmd_valid and cmd_ready are both 1. An accepted PUSH (cmd_op 3'd0) on a non-full stack makes cmd_data the new top and raises depth by one, visible in the following cycle.
- R3: An accepted POP (cmd_op 3'd1) on a non-empty stack lowers depth by one. In the following cycle it raises pop_valid for exactly one cycle, with pop_data equal to the removed top. When the stack is empty, tos reads 0.
- R4: SUB (3'd2), ADD (3'd3) and MUL (3'd4) replace the two top entries with next OP top: the unsigned difference modulo 2^16, the sum modulo 2^16, or the low 16 bits of the product. Depth drops by one, and the result is visible in the following cycle.
- R5: DIV (3'd5) with a nonzero top replaces the two top entries with the truncated unsigned quotient next/top. cmd_ready is low in the cycle after acceptance and stays low until the quotient is on top, which takes at most 18 cycles.
- R6: A PUSH on a full stack (depth 8) sets err_ovf and leaves depth and all entries unchanged.
- R7: A POP on an empty stack, or a binary operation with fewer than two entries, sets err_unf and leaves depth and all entries unchanged.
- R8: DIV with a top of zero sets err_dz, replaces the two top entries with 0 and lowers depth by one, completing without a busy period.
- R9: Every accepted command sets the three error flags to describe its own outcome, clearing the flags of the previous command. The flags hold until the next accepted command, and at most one of them is 1.
- R10: Opcodes 3'd6 and 3'd7 change neither depth nor entries, raise no pop_valid and clear all error flags.
- R11: Entries leave the stack in last-in first-out order. PUSH A, PUSH B, SUB, PUSH C, PUSH D, PUSH E, MUL, ADD, DIV leaves exactly one entry, equal to (A-B)/(C+D*E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command this cycle |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 sub, 3 add, 4 mul, 5 div) |
| cmd_data | input | 16 | Word to push |
| pop_valid | output | 1 | One-cycle pulse after a successful pop |
| pop_data | output | 16 | Word removed by the last pop |
| tos | output | 16 | Current top entry, 0 when empty |
| depth | output | 4 | Number of entries held |
| err_ovf | output | 1 | Last command pushed onto a full stack |
| err_unf | output | 1 | Last command lacked operands |
| err_dz | output | 1 | Last command divided by zero |

## Verification
A corrupted pointer appears on the depth and tos ports in the cycle right after the faulty command. Each command is compared against an independent stack model, so such a fault is caught one command later at most. A wrong entry below the top stays hidden until a pop or a binary operation brings it up. For that reason random sequences often drain the stack and check every popped word. Divider faults surface as a wrong top, or as cmd_ready returning at the wrong time, once the division completes.

// File: rtl/stack_calc_pkg.sv
// Shared command encoding for the stack arithmetic unit.
// Assumes a 3-bit command field; codes 6 and 7 are reserved no-ops.
package stack_calc_pkg;

    typedef enum logic [2:0] {
        CMD_PUSH = 3'd0,
        CMD_POP  = 3'd1,
        CMD_SUB  = 3'd2,
        CMD_ADD  = 3'd3,
        CMD_MUL  = 3'd4,
        CMD_DIV  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } cmd_e;

endpackage

// File: rtl/stack_store.sv
// Register-based operand stack with a fill counter.
// Supports push, pop and replace-two-with-one (binary result) per cycle.
// Assumes the controller never requests an illegal move (checks done upstream).
module stack_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_push,
    input  logic          do_pop,
    input  logic          do_repl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] top_q,
    output logic [DW-1:0] next_q,
    output logic [CW-1:0] fill
);

    logic [DW-1:0] slot [DEPTH];
    logic [CW-1:0] top_pos;
    logic [CW-1:0] next_pos;
    logic [CW-1:0] wr_pos;
    logic          wr_en;

    // Positions of the top and the entry below it.
    always_comb begin
        top_pos  = fill - CW'(1);
        next_pos = fill - CW'(2);
    end

    // Select write slot: push writes above top, replace writes the next slot.
    always_comb begin
        wr_en  = do_push | do_repl;
        wr_pos = do_push ? fill : next_pos;
    end

    // One write port per slot, each decoding the shared write position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_pos[AW-1:0] == AW'(g))) begin
                slot[g] <= wdata;
            end
        end
    end

    // Fill counter: push adds one, pop and replace remove one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (do_push) begin
            fill <= fill + CW'(1);
        end else if (do_pop || do_repl) begin
            fill <= fill - CW'(1);
        end
    end

    // Read ports, zero when the addressed entry does not exist.
    always_comb begin
        top_q  = (fill >= CW'(1)) ? slot[top_pos[AW-1:0]]  : '0;
        next_q = (fill >= CW'(2)) ? slot[next_pos[AW-1:0]] : '0;
    end

endmodule

// File: rtl/stack_alu.sv
// Single-cycle integer operations on (left OP right), unsigned, modulo 2^DW.
// Assumes left is the second entry and right the top entry.
module stack_alu #(
    parameter int DW = 16
) (
    input  stack_calc_pkg::cmd_e op,
    input  logic [DW-1:0]        left,
    input  logic [DW-1:0]        right,
    output logic [DW-1:0]        result
);
    import stack_calc_pkg::*;

    // Pick the operation; non-arithmetic codes yield zero.
    always_comb begin
        unique case (op)
            CMD_SUB: result = left - right;
            CMD_ADD: result = left + right;
            CMD_MUL: result = left * right;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/stack_divider.sv
// Iterative restoring unsigned divider, one quotient bit per cycle.
// Assumes divisor is nonzero at start; start is ignored while busy or done.
// done pulses for one cycle after the last iteration, with quot valid.
module stack_divider #(
    parameter int DW = 16,
    localparam int NW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quot
);

    logic [DW-1:0] rem;
    logic [DW-1:0] dsr;
    logic [NW-1:0] step;
    logic [DW:0]   shifted;
    logic          fits;

    // Trial step: shift in the next dividend bit and compare.
    always_comb begin
        shifted = {rem, quot[DW-1]};
        fits    = shifted >= {1'b0, dsr};
    end

    // Iteration state, counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dsr  <= '0;
            quot <= '0;
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                rem  <= fits ? DW'(shifted - {1'b0, dsr}) : shifted[DW-1:0];
                quot <= {quot[DW-2:0], fits};
                step <= step + NW'(1);
                if (step == NW'(DW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start && !done) begin
                rem  <= '0;
                dsr  <= divisor;
                quot <= dividend;
                step <= '0;
                busy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/stack_calc.sv
// Zero-address stack arithmetic unit: push, pop and binary operations on
// the two top entries (second OP top) behind a valid/ready command port.
// Assumes one command per handshake; division stalls the port until done.
module stack_calc #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          pop_valid,
    output logic [DW-1:0] pop_data,
    output logic [DW-1:0] tos,
    output logic [CW-1:0] depth,
    output logic          err_ovf,
    output logic          err_unf,
    output logic          err_dz
);
    import stack_calc_pkg::*;

    cmd_e          op;
    logic          accept;
    logic          is_full;
    logic          has_one;
    logic          has_two;
    logic [DW-1:0] nos;
    logic [DW-1:0] alu_res;
    logic          div_start;
    logic          div_busy;
    logic          div_done;
    logic [DW-1:0] div_quot;
    logic          st_push;
    logic          st_pop;
    logic          st_repl;
    logic [DW-1:0] st_wdata;
    logic          nx_ovf;
    logic          nx_unf;
    logic          nx_dz;

    // Decode handshake and occupancy conditions.
    always_comb begin
        op        = cmd_e'(cmd_op);
        cmd_ready = !div_busy && !div_done;
        accept    = cmd_valid && cmd_ready;
        is_full   = depth == CW'(DEPTH);
        has_one   = depth >= CW'(1);
        has_two   = depth >= CW'(2);
    end

    // Choose the stack move and the outcome flags for this cycle.
    always_comb begin
        st_push   = 1'b0;
        st_pop    = 1'b0;
        st_repl   = 1'b0;
        st_wdata  = cmd_data;
        div_start = 1'b0;
        nx_ovf    = 1'b0;
        nx_unf    = 1'b0;
        nx_dz     = 1'b0;
        if (div_done) begin
            st_repl  = 1'b1;
            st_wdata = div_quot;
        end else if (accept) begin
            unique case (op)
                CMD_PUSH: begin
                    if (is_full) nx_ovf = 1'b1;
                    else         st_push = 1'b1;
                end
                CMD_POP: begin
                    if (!has_one) nx_unf = 1'b1;
                    else          st_pop = 1'b1;
                end
                CMD_SUB, CMD_ADD, CMD_MUL: begin
                    if (!has_two) begin
                        nx_unf = 1'b1;
                    end else begin
                        st_repl  = 1'b1;
                        st_wdata = alu_res;
                    end
                end
                CMD_DIV: begin
                    if (!has_two) begin
                        nx_unf = 1'b1;
                    end else if (tos == '0) begin
                        nx_dz    = 1'b1;
                        st_repl  = 1'b1;
                        st_wdata = '0;
                    end else begin
                        div_start = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the outcome flags and the pop return path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_ovf   <= 1'b0;
            err_unf   <= 1'b0;
            err_dz    <= 1'b0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= st_pop;
            if (st_pop) pop_data <= tos;
            if (accept) begin
                err_ovf <= nx_ovf;
                err_unf <= nx_unf;
                err_dz  <= nx_dz;
            end
        end
    end

    stack_store #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_push (st_push),
        .do_pop  (st_pop),
        .do_repl (st_repl),
        .wdata   (st_wdata),
        .top_q   (tos),
        .next_q  (nos),
        .fill    (depth)
    );

    stack_alu #(
        .DW (DW)
    ) u_alu (
        .op     (op),
        .left   (nos),
        .right  (tos),
        .result (alu_res)
    );

    stack_divider #(
        .DW (DW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (nos),
        .divisor  (tos),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (div_quot)
    );

endmodule

// File: rtl/stack_calc_chk.sv
// Port-level properties of the stack arithmetic unit, bound to every instance.
module stack_calc_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_op,
    input logic [DW-1:0] cmd_data,
    input logic          pop_valid,
    input logic [DW-1:0] pop_data,
    input logic [DW-1:0] tos,
    input logic [CW-1:0] depth,
    input logic          err_ovf,
    input logic          err_unf,
    input logic          err_dz
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=>
        (depth == '0 && !pop_valid && !err_ovf && !err_unf && !err_dz));

    // R2
    push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd0 && depth < CW'(DEPTH)) |=>
        (depth == $past(depth) + CW'(1) && tos == $past(cmd_data)));

    // R3
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(acc && cmd_op == 3'd1 && depth != '0));

    // R3
    pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1 && depth != '0) |=> (pop_valid && pop_data == $past(tos)));

    // R5
    div_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd5 && depth >= CW'(2) && tos != '0) |=> !cmd_ready);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd0 && depth == CW'(DEPTH)) |=>
        (err_ovf && $stable(depth) && $stable(tos)));

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1 && depth == '0) |=> (err_unf && depth == '0 && !pop_valid));

    // R9
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_ovf, err_unf, err_dz}));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(err_ovf) && $stable(err_unf) && $stable(err_dz)));

    // R10
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op[2:1] == 2'b11) |=>
        ($stable(depth) && $stable(tos) && !err_ovf && !err_unf && !err_dz));

endmodule

bind stack_calc stack_calc_chk #(
    .DW    (DW),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .tos       (tos),
    .depth     (depth),
    .err_ovf   (err_ovf),
    .err_unf   (err_unf),
    .err_dz    (err_dz)
);

// File: tb/test_stack_calc.sv
// Self-checking bench: directed corners plus seeded random command streams,
// compared against a behavioural stack model.
module test_stack_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        pop_valid;
    logic [15:0] pop_data;
    logic [15:0] tos;
    logic [3:0]  depth;
    logic        err_ovf;
    logic        err_unf;
    logic        err_dz;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [15:0] m [8];
    int          mcnt = 0;
    logic        e_ovf, e_unf, e_dz, e_pv;
    logic [15:0] e_pd;

    always #2 clk = ~clk;

    stack_calc i_stack_calc (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_op (cmd_op), .cmd_data (cmd_data), .pop_valid (pop_valid),
        .pop_data (pop_data), .tos (tos), .depth (depth), .err_ovf (err_ovf),
        .err_unf (err_unf), .err_dz (err_dz)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] calc(input logic [2:0] op, input logic [15:0] a,
                                         input logic [15:0] b);
        case (op)
            3'd2:    return a - b;
            3'd3:    return a + b;
            3'd4:    return 16'(a * b);
            3'd5:    return (b == 0) ? 16'd0 : a / b;
            default: return 16'd0;
        endcase
    endfunction

    // Update the model for one command (R2..R10).
    task automatic model(input logic [2:0] op, input logic [15:0] d);
        e_ovf = 0; e_unf = 0; e_dz = 0; e_pv = 0;
        case (op)
            3'd0: if (mcnt == 8) e_ovf = 1; else begin m[mcnt] = d; mcnt++; end
            3'd1: if (mcnt == 0) e_unf = 1; else begin mcnt--; e_pv = 1; e_pd = m[mcnt]; end
            3'd2, 3'd3, 3'd4, 3'd5: begin
                if (mcnt < 2) e_unf = 1;
                else begin
                    if (op == 3'd5 && m[mcnt-1] == 0) e_dz = 1;
                    m[mcnt-2] = calc(op, m[mcnt-2], m[mcnt-1]);
                    mcnt--;
                end
            end
            default: ;
        endcase
    endtask

    // Drive one command and compare all outputs once it has finished.
    task automatic issue(input logic [2:0] op, input logic [15:0] d);
        int waitc;
        logic [15:0] etos;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_data = d;
        model(op, d);
        @(negedge clk);
        cmd_valid = 0;
        // R3: pop pulse in the cycle after acceptance
        chk(pop_valid == e_pv, "R3 pop_valid", pop_valid, e_pv);
        if (e_pv) chk(pop_data == e_pd, "R3 pop_data", pop_data, e_pd);
        waitc = 0;
        // R5: divider stall lasts a bounded number of cycles
        if (op == 3'd5 && !e_unf && !e_dz)
            chk(!cmd_ready, "R5 ready low after DIV", cmd_ready, 0);
        while (!cmd_ready) begin
            @(negedge clk);
            waitc++;
        end
        if (op == 3'd5) chk(waitc <= 17, "R5 stall length", waitc, 17);
        etos = (mcnt == 0) ? 16'd0 : m[mcnt-1];
        chk(depth == 4'(mcnt), "R2/R4/R7 depth", depth, mcnt);
        chk(tos == etos, "R4/R11 tos", tos, etos);
        chk(err_ovf == e_ovf, "R6/R9 err_ovf", err_ovf, e_ovf);
        chk(err_unf == e_unf, "R7/R9 err_unf", err_unf, e_unf);
        chk(err_dz == e_dz, "R8/R9 err_dz", err_dz, e_dz);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(depth == 0 && tos == 0, "R1 empty after reset", depth, 0);
        chk(!err_ovf && !err_unf && !err_dz && !pop_valid, "R1 flags", err_unf, 0);
        chk(cmd_ready, "R1 ready", cmd_ready, 1);

        // R11: (A-B)/(C+D*E) with A=100 B=20 C=3 D=2 E=7 -> 80/17 = 4
        issue(3'd0, 16'd100); issue(3'd0, 16'd20); issue(3'd2, 16'd0);
        issue(3'd0, 16'd3); issue(3'd0, 16'd2); issue(3'd0, 16'd7);
        issue(3'd4, 16'd0); issue(3'd3, 16'd0); issue(3'd5, 16'd0);
        chk(depth == 1 && tos == 16'd4, "R11 expression result", tos, 4);
        issue(3'd1, 16'd0);

        // R7: underflow on empty pop and on short binary operations
        issue(3'd1, 16'd0); issue(3'd3, 16'd0);
        issue(3'd0, 16'd9); issue(3'd5, 16'd0); issue(3'd1, 16'd0);

        // R4: subtraction order and wrap
        issue(3'd0, 16'd5); issue(3'd0, 16'd9); issue(3'd2, 16'd0);
        chk(tos == 16'hFFFC, "R4 next minus top wraps", tos, 16'hFFFC);
        // R8: divide by zero
        issue(3'd0, 16'd0); issue(3'd5, 16'd0);
        chk(err_dz && tos == 0, "R8 div zero result", tos, 0);
        issue(3'd1, 16'd0);

        // R6: fill, overflow, then R10 reserved codes, then LIFO drain
        for (int i = 0; i < 8; i++) issue(3'd0, 16'(i * 11 + 1));
        issue(3'd0, 16'hBEEF);
        chk(err_ovf && tos == 16'd78, "R6 overflow keeps top", tos, 78);
        issue(3'd6, 16'h1234); issue(3'd7, 16'h5678);
        for (int i = 0; i < 8; i++) issue(3'd1, 16'd0);
        // R5: largest quotient
        issue(3'd0, 16'hFFFF); issue(3'd0, 16'd1); issue(3'd5, 16'd0);
        chk(tos == 16'hFFFF, "R5 quotient by one", tos, 16'hFFFF);
        issue(3'd1, 16'd0);

        // Random mix of all commands
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic [15:0] d;
            r = int'($urandom % 16);
            d = ($urandom % 6 == 0) ? 16'(($urandom % 3)) : 16'($urandom);
            if (r < 6)       issue(3'd0, d);
            else if (r < 9)  issue(3'd1, d);
            else if (r == 9) issue(3'd2, d);
            else if (r == 10) issue(3'd3, d);
            else if (r == 11) issue(3'd4, d);
            else if (r < 14) issue(3'd5, d);
            else             issue(3'(6 + (r & 1)), d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule